// File: doc/BRIEF.md
# Dual-Width ROM Read Port

This block is a synthesizable behavioural model of a read-only memory that is 16 bits wide and can also be read one byte at a time. It is meant to stand in as the target device when a device programmer or a bus bridge is verified. Every data line comes with its own drive enable, so a bench can see exactly which lines float in each cycle. A small register array holds the contents. A separate program port can only clear bits in it, which matches a one-time-programmable part that starts out fully erased.

Reads are gated by an active-low chip select and an active-low output enable. Access delays are counted in clock cycles. The slow path covers a change of address, chip select, width mode, byte-select bit or identification strobe, and it takes `T_ACC` edges. A change of output enable alone takes `T_OE` edges, which is shorter. In byte mode the upper eight lines float and a low-order byte-select input steers one half of the addressed word onto lines 7..0. In identification mode every address bit except bit 0 is ignored, and the port returns one of two fixed 16-bit codes, each of odd parity.

Top module: `dwrom_port`

## Requirements
- R1: While `ce_n` is high, `dq_oe` is 0 and `dq_out` is 0 from the first clock edge that sees it, whatever `oe_n` is.
- R2: While `ce_n` is low and `oe_n` is high, `dq_oe` is 0 from the first clock edge that sees `oe_n` high.
- R3: In word mode (`byte_sel`=0) a completed read drives `dq_oe`=16'hFFFF, and `dq_out` carries the stored word with bit i on line i.
- R4: In byte mode (`byte_sel`=1) a completed read drives `dq_oe`=16'h00FF with lines 15..8 reading 0. `lo_bit`=1 puts word bits 15..8 on lines 7..0, and `lo_bit`=0 puts word bits 7..0 there.
- R5: With `id_mode`=1, address bits above bit 0 have no effect. `addr[0]`=0 returns `MFR_CODE` (default 16'h00C2) and `addr[0]`=1 returns `DEV_CODE` (default 16'h8151).
- R6: Both identification codes have odd parity over all 16 bits, with bit 15 acting as the parity bit, so a driven identification word always has an odd number of ones.
- R7: After reset every word reads 16'hFFFF. A program write (`prog_we`=1 at an edge) replaces the word at `prog_addr` with its old value AND `prog_data`, so a write can clear bits but can never set them.
- R8: When `addr`, `ce_n`, `byte_sel`, `lo_bit` or `id_mode` changes, the lines stay undriven after edges 0 to `T_ACC`-1 (default 4), counted from the first edge that sees the change. They are driven from edge `T_ACC` onward.
- R9: With the address path already settled, lowering `oe_n` leaves the lines undriven after edges 0 to `T_OE`-1 (default 2) and drives them from edge `T_OE` onward.
- R10: A program write to the word currently being read and driven changes `dq_out` to the cleared word right after the write edge, and the drive does not drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; erases the array |
| addr | input | ADDR_W | Word address for reads |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| byte_sel | input | 1 | 1 = byte-wide reads, 0 = word-wide reads |
| lo_bit | input | 1 | Byte-select bit used in byte mode (1 = upper half) |
| id_mode | input | 1 | Identification-code read strobe |
| prog_we | input | 1 | Program write strobe |
| prog_addr | input | ADDR_W | Program write address |
| prog_data | input | 16 | Program pattern; 0 bits clear cells |
| dq_out | output | 16 | Data lines (0 where undriven) |
| dq_oe | output | 16 | Per-line drive enable |

## Verification
A program write can land on the same edge as a read of that same word that is already being driven. The bench lets a read of an erased word settle, asserts a write to that address half a cycle before an edge, and checks two things: the erased value just before the edge, and the cleared value with full drive kept right after it. Latency boundaries are judged one edge before and exactly at the expected edge. The identification codes are checked both in value and in parity.

// File: rtl/dwrom_pkg.sv
`timescale 1ns/1ps
package dwrom_pkg;
  localparam int DATA_W = 16;
  localparam int HALF_W = DATA_W / 2;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] en;
  } lanes_t;

  // 1 when the vector holds an odd number of ones
  function automatic logic odd_parity(input logic [DATA_W-1:0] v);
    return ^v;
  endfunction

  // one-time-programmable cell update: only 1 -> 0 transitions
  function automatic logic [DATA_W-1:0] burn(input logic [DATA_W-1:0] old_w,
                                             input logic [DATA_W-1:0] pat);
    return old_w & pat;
  endfunction

  // lane steering for word and byte access
  function automatic lanes_t steer(input logic [DATA_W-1:0] word,
                                   input logic byte_mode,
                                   input logic hi_half,
                                   input logic live);
    lanes_t r;
    r.data = '0;
    r.en   = '0;
    if (live) begin
      if (byte_mode) begin
        r.data[HALF_W-1:0] = hi_half ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];
        r.en[HALF_W-1:0]   = '1;
      end else begin
        r.data = word;
        r.en   = '1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/dwrom_age.sv
`timescale 1ns/1ps
module dwrom_age #(
  parameter int KEY_W = 4,
  parameter int LIMIT = 4,
  parameter logic [KEY_W-1:0] RST_KEY = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key,
  output logic [KEY_W-1:0] key_q,
  output logic             restart,
  output logic             ready
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] age;

  assign restart = (key != key_q);
  assign ready   = (age == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= RST_KEY;
      age   <= '0;
    end else if (restart) begin
      key_q <= key;
      age   <= '0;
    end else if (!ready) begin
      age <= age + 1'b1;
    end
  end
endmodule

// File: rtl/dwrom_array.sv
`timescale 1ns/1ps
module dwrom_array
  import dwrom_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] wr_cur
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  assign rd_data = cells[rd_addr];
  assign wr_cur  = cells[wr_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[wr_addr] <= burn(cells[wr_addr], wr_data);
    end
  end
endmodule

// File: rtl/dwrom_lane_mux.sv
`timescale 1ns/1ps
module dwrom_lane_mux
  import dwrom_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  input  logic              byte_mode,
  input  logic              hi_half,
  input  logic              live,
  output logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] en
);
  lanes_t l;
  assign l    = steer(word, byte_mode, hi_half, live);
  assign data = l.data;
  assign en   = l.en;
endmodule

// File: rtl/dwrom_port.sv
`timescale 1ns/1ps
module dwrom_port
  import dwrom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int T_ACC  = 4,
  parameter int T_OE   = 2,
  parameter logic [15:0] MFR_CODE = 16'h00C2,
  parameter logic [15:0] DEV_CODE = 16'h8151
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              byte_sel,
  input  logic              lo_bit,
  input  logic              id_mode,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [15:0]       prog_data,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe
);
  localparam int KEY_W = ADDR_W + 4;
  localparam logic [KEY_W-1:0] KEY_RST = {1'b1, {(KEY_W-1){1'b0}}};

  // captured access path: {ce_n, id_mode, byte_sel, lo_bit, addr}
  logic [KEY_W-1:0]  acc_key, acc_q;
  logic              acc_restart, acc_ready;
  logic              oe_q, oe_restart, oe_ready;
  logic              ce_q, id_q, byte_q, lo_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] arr_word, wr_old, sel_word;

  // named events for the checker
  logic              read_live;
  logic              id_live;
  logic              byte_live;

  assign acc_key = {ce_n, id_mode, byte_sel, lo_bit, addr};

  dwrom_age #(.KEY_W(KEY_W), .LIMIT(T_ACC), .RST_KEY(KEY_RST)) u_acc_age (
    .clk(clk), .rst_n(rst_n), .key(acc_key),
    .key_q(acc_q), .restart(acc_restart), .ready(acc_ready)
  );

  dwrom_age #(.KEY_W(1), .LIMIT(T_OE), .RST_KEY(1'b1)) u_oe_age (
    .clk(clk), .rst_n(rst_n), .key(oe_n),
    .key_q(oe_q), .restart(oe_restart), .ready(oe_ready)
  );

  assign {ce_q, id_q, byte_q, lo_q, addr_q} = acc_q;

  dwrom_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(prog_we), .wr_addr(prog_addr), .wr_data(prog_data),
    .rd_addr(addr_q), .rd_data(arr_word), .wr_cur(wr_old)
  );

  assign sel_word  = id_q ? (addr_q[0] ? DEV_CODE : MFR_CODE) : arr_word;
  assign read_live = !ce_q && !oe_q && acc_ready && oe_ready;
  assign id_live   = read_live && id_q;
  assign byte_live = byte_q;

  dwrom_lane_mux u_mux (
    .word(sel_word), .byte_mode(byte_q), .hi_half(lo_q), .live(read_live),
    .data(dq_out), .en(dq_oe)
  );
endmodule

// File: rtl/dwrom_port_chk.sv
`timescale 1ns/1ps
module dwrom_port_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              byte_sel,
  input logic              prog_we,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [15:0]       prog_data,
  input logic [15:0]       wr_old,
  input logic              id_live,
  input logic              byte_live,
  input logic [15:0]       dq_out,
  input logic [15:0]       dq_oe
);
  assert_standby_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (dq_oe == 16'h0 && dq_out == 16'h0));

  assert_oe_off_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> (dq_oe == 16'h0));

  assert_byte_upper_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sel |=> (dq_oe[15:8] == 8'h0));

  assert_id_odd_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_live && !byte_live) |-> ($countones(dq_out) % 2 == 1));

  assert_burn_clears_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> ((prog_addr != $past(prog_addr)) ||
                 (((wr_old & ~$past(wr_old)) == 16'h0) &&
                  ((wr_old & ~$past(prog_data)) == 16'h0))));

  assert_addr_change_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |=> (dq_oe == 16'h0));

  assert_oe_change_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n != $past(oe_n)) |=> (dq_oe == 16'h0));
endmodule

bind dwrom_port dwrom_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
  .byte_sel(byte_sel), .prog_we(prog_we), .prog_addr(prog_addr),
  .prog_data(prog_data), .wr_old(wr_old), .id_live(id_live),
  .byte_live(byte_live), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/tb_dwrom_port.sv
`timescale 1ns/1ps
module tb_dwrom_port;
  localparam int AW    = 6;
  localparam int TACC  = 4;
  localparam int TOE   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1, oe_n = 1'b1, byte_sel = 1'b0, lo_bit = 1'b0, id_mode = 1'b0;
  logic          prog_we = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [15:0]   prog_data = '0;
  logic [15:0]   dq_out, dq_oe;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  dwrom_port #(.ADDR_W(AW), .T_ACC(TACC), .T_OE(TOE)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .byte_sel(byte_sel), .lo_bit(lo_bit), .id_mode(id_mode),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_rd(input logic [AW-1:0] a, input logic ce, input logic oe,
                        input logic bm, input logic lo, input logic id);
    @(negedge clk);
    addr = a; ce_n = ce; oe_n = oe; byte_sel = bm; lo_bit = lo; id_mode = id;
  endtask

  task automatic burn_word(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = a; prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset dq_oe", dq_oe, 16'h0);
    chk("R1 reset dq_out", dq_out, 16'h0);
    set_rd(6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    edges(TACC + 1);
    chk("R7 erased word", dq_out, 16'hFFFF);
    chk("R3 erased drive", dq_oe, 16'hFFFF);
  endtask

  task automatic t_program;
    burn_word(6'd3, 16'hA5F0);
    set_rd(6'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    edges(TACC + 1);
    chk("R7 first burn", dq_out, 16'hA5F0);
    burn_word(6'd3, 16'h0FFF);
    edges(1);
    chk("R7 second burn ANDs", dq_out, 16'h05F0);
    burn_word(6'd3, 16'hFFFF);
    edges(1);
    chk("R7 ones cannot set", dq_out, 16'h05F0);
  endtask

  task automatic t_word_latency;
    burn_word(6'd7, 16'h3C96);
    burn_word(6'd12, 16'h5A0F);
    set_rd(6'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    edges(TACC);
    chk("R8 early addr undriven", dq_oe, 16'h0);
    edges(1);
    chk("R8 drive at T_ACC", dq_oe, 16'hFFFF);
    chk("R3 word 7", dq_out, 16'h3C96);
    set_rd(6'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    edges(TACC);
    chk("R8 addr change undriven", dq_oe, 16'h0);
    edges(1);
    chk("R3 word 12", dq_out, 16'h5A0F);
  endtask

  task automatic t_oe_path;
    set_rd(6'd12, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    edges(1);
    chk("R2 oe high float", dq_oe, 16'h0);
    edges(6);
    chk("R2 oe high stays float", dq_oe, 16'h0);
    set_rd(6'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    edges(TOE);
    chk("R9 early oe undriven", dq_oe, 16'h0);
    edges(1);
    chk("R9 drive at T_OE", dq_oe, 16'hFFFF);
    chk("R9 data at T_OE", dq_out, 16'h5A0F);
  endtask

  task automatic t_standby;
    set_rd(6'd12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    edges(1);
    chk("R1 standby float", dq_oe, 16'h0);
    edges(6);
    chk("R1 standby stays float", dq_oe, 16'h0);
    chk("R1 standby data zero", dq_out, 16'h0);
  endtask

  task automatic t_byte;
    set_rd(6'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    edges(TACC + 1);
    chk("R4 byte enables", dq_oe, 16'h00FF);
    chk("R4 upper half", dq_out, 16'h003C);
    set_rd(6'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    edges(TACC);
    chk("R8 lo_bit change undriven", dq_oe, 16'h0);
    edges(1);
    chk("R4 lower half", dq_out, 16'h0096);
  endtask

  task automatic t_ident;
    set_rd(6'h2A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    edges(TACC + 1);
    chk("R5 maker code", dq_out, 16'h00C2);
    chk("R6 maker parity", {15'd0, ^dq_out}, 16'h1);
    set_rd(6'h3B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    edges(TACC + 1);
    chk("R5 device code", dq_out, 16'h8151);
    chk("R6 device parity", {15'd0, ^dq_out}, 16'h1);
    set_rd(6'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    edges(TACC + 1);
    chk("R5 upper bits ignored", dq_out, 16'h8151);
    set_rd(6'h01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    edges(TACC + 1);
    chk("R5 id byte upper", dq_out, 16'h0081);
  endtask

  task automatic t_same_cycle;
    set_rd(6'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    edges(TACC + 1);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 6'd20; prog_data = 16'hF00F;
    chk("R10 before write edge", dq_out, 16'hFFFF);
    edges(1);
    chk("R10 after write edge", dq_out, 16'hF00F);
    chk("R10 drive kept", dq_oe, 16'hFFFF);
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    edges(3);
    @(negedge clk);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_program();
    t_word_latency();
    t_oe_path();
    t_standby();
    t_byte();
    t_ident();
    t_same_cycle();
    edges(2);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule